// File: doc/BRIEF.md
# Sample Ring Buffer with Fill-Threshold Interrupt

This block is the device-side store for converted samples that a host drains through a shared-memory window. A producer pushes one sample per cycle into the entry at the write index. The write index then advances and wraps at the configured depth, which need not be a power of two. The host reads entries through an addressed read port. When it has drained them, it writes back its own consumer index. From the two indices the block derives the fill level modulo the depth.

An eight-bit interrupt flag register collects events. The fill-threshold event and the overrun event are raised internally. The other six come from neighbouring logic through a set vector. A mask register selects which flags drive the single interrupt line. Writing an all-zero mask silences the line, which is what the host does when acquisition stops. The fill threshold is programmable and resets to half the depth.

Top module: `cbuf_sample_ring`

## Requirements
- R1: After reset the write index, consumer index, fill level, flags, mask and read data are all zero, and the threshold equals DEPTH/2 (1001 for DEPTH = 2003).
- R2: An accepted push stores `prod_data` at the current write index and advances `front_ptr` by one. The index goes from DEPTH-1 back to 0.
- R3: A push arriving while the fill level equals DEPTH-1 is dropped. `front_ptr` stays unchanged and flag bit 1 (overrun) is set on that same clock edge.
- R4: `fill_level` equals front minus rear when front is not below rear, and front plus DEPTH minus rear otherwise.
- R5: A consumer-index write with a value below DEPTH loads `rear_ptr` on the next edge. A value of DEPTH or more is ignored and `rear_ptr` keeps its value.
- R6: On every edge where the fill level is at or above the threshold, flag bit 0 is set. A threshold write loads the new value on the next edge.
- R7: Flags are sticky. A flag clear write with a 1 at a bit position clears that flag, but a set on the same edge wins over the clear.
- R8: Each bit of `evt_set` sets the flag at the same position on the next edge. The positions are: bit 0 fill threshold, bit 1 input overrun, bit 2 input hardware fault, bit 3 output empty, bit 4 output overrun, bit 5 output hardware fault, bit 6 counter done, bit 7 command done.
- R9: `irq` is high exactly when some flag bit and the same mask bit are both 1. With an all-zero mask, `irq` stays low whatever the flags.
- R10: The read port returns the entry at `host_rd_addr` on the edge after `host_rd_en` and holds its value while `host_rd_en` is low. An address of DEPTH or more returns zero. A read and a push to the same index on one edge return the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer push strobe |
| prod_data | input | DATA_W | Sample to store |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | PTR_W | Entry index to read |
| host_rd_data | output | DATA_W | Read data, one cycle after strobe |
| rear_wr | input | 1 | Consumer index write strobe |
| rear_wdata | input | PTR_W | New consumer index |
| thresh_wr | input | 1 | Threshold write strobe |
| thresh_wdata | input | PTR_W | New fill threshold |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New interrupt mask |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_data | input | 8 | Ones clear the matching flags |
| evt_set | input | 8 | Event pulses from neighbouring logic |
| front_ptr | output | PTR_W | Producer write index |
| rear_ptr | output | PTR_W | Host consumer index |
| fill_level | output | PTR_W | Entries held |
| threshold | output | PTR_W | Current fill threshold |
| int_mask | output | 8 | Current interrupt mask |
| int_flags | output | 8 | Current interrupt flags |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: a depth of 2003 and 16-bit samples. The odd depth means the write index only wraps through the compare-based path. Filling the ring to its 2002-entry capacity takes about two thousand cycles, so the overrun drop, the wrap from 2002 to 0 and the default threshold of 1001 are all reached in one short run. Out-of-range indices between 2003 and 2047 exist in the 11-bit index space. They exercise both the ignored consumer write and the zero read.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    localparam int unsigned FLAG_W = 8;

    localparam int unsigned FLG_FILL_HIT  = 0;
    localparam int unsigned FLG_IN_OVRUN  = 1;
    localparam int unsigned FLG_IN_HWERR  = 2;
    localparam int unsigned FLG_OUT_EMPTY = 3;
    localparam int unsigned FLG_OUT_OVRUN = 4;
    localparam int unsigned FLG_OUT_HWERR = 5;
    localparam int unsigned FLG_CNT_DONE  = 6;
    localparam int unsigned FLG_CMD_DONE  = 7;

    typedef logic [FLAG_W-1:0] flag_vec_t;

    // Events raised inside the ring itself
    typedef struct packed {
        logic fill_hit;
        logic overrun;
    } ring_evt_t;

    // Next index with wrap by comparison (depth need not be a power of two)
    function automatic int unsigned ring_step(input int unsigned idx, input int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

    // Occupancy between producer and consumer indices
    function automatic int unsigned ring_level(input int unsigned fr, input int unsigned rr,
                                               input int unsigned depth);
        return (fr >= rr) ? fr - rr : fr + depth - rr;
    endfunction

endpackage

// File: rtl/cbuf_ptr_ctrl.sv
module cbuf_ptr_ctrl
    import cbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 2003,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             rear_wr,
    input  logic [PTR_W-1:0] rear_wdata,
    output logic [PTR_W-1:0] front,
    output logic [PTR_W-1:0] rear,
    output logic [PTR_W-1:0] fill,
    output logic             full,
    output logic             push_ok
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] front_q, rear_q;
    logic             rear_ok;

    always_comb begin
        fill    = PTR_W'(ring_level(32'(front_q), 32'(rear_q), DEPTH));
        full    = (fill == LAST_IDX);
        push_ok = push && !full;
        rear_ok = rear_wr && (32'(rear_wdata) < DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
            rear_q  <= '0;
        end else begin
            if (push_ok)
                front_q <= PTR_W'(ring_step(32'(front_q), DEPTH));
            if (rear_ok)
                rear_q <= rear_wdata;
        end
    end

    assign front = front_q;
    assign rear  = rear_q;

    // Dropped push leaves the write index alone (R3)
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(front_q));

    // Write index wraps to zero after the last entry (R2)
    assert_front_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !full && front_q == LAST_IDX) |=> (front_q == '0));

    // Occupancy never exceeds capacity (R4)
    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
        32'(fill) <= DEPTH - 1);

    // Consumer index always inside the ring (R5)
    assert_rear_range_R5: assert property (@(posedge clk) disable iff (rst)
        32'(rear_q) < DEPTH);

endmodule

// File: rtl/cbuf_store.sv
module cbuf_store #(
    parameter int unsigned DEPTH  = 2003,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              rd_in_range;

    assign rd_in_range = (32'(rd_addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read sees the content before a same-edge write
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= rd_in_range ? mem[rd_addr] : '0;
    end

    assign rd_data = rd_q;

    // Read data holds between strobes (R10)
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

    // Out-of-range address yields zero (R10)
    assert_rd_oob_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_in_range) |=> (rd_q == '0));

endmodule

// File: rtl/cbuf_irq_regs.sv
module cbuf_irq_regs
    import cbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 2003,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] fill,
    input  logic             overrun,
    input  logic             thr_wr,
    input  logic [PTR_W-1:0] thr_wdata,
    input  logic             mask_wr,
    input  flag_vec_t        mask_wdata,
    input  logic             clr_wr,
    input  flag_vec_t        clr_data,
    input  flag_vec_t        evt_set,
    output logic [PTR_W-1:0] thr,
    output flag_vec_t        mask,
    output flag_vec_t        flags,
    output logic             irq
);

    localparam logic [PTR_W-1:0] THR_RESET = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0] thr_q;
    flag_vec_t        mask_q;
    flag_vec_t        flags_q;
    flag_vec_t        set_v;
    ring_evt_t        ring_evt;

    always_comb begin
        ring_evt.fill_hit = (fill >= thr_q);
        ring_evt.overrun  = overrun;
        set_v = evt_set;
        set_v[FLG_FILL_HIT] = evt_set[FLG_FILL_HIT] | ring_evt.fill_hit;
        set_v[FLG_IN_OVRUN] = evt_set[FLG_IN_OVRUN] | ring_evt.overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= THR_RESET;
            mask_q <= '0;
        end else begin
            if (thr_wr)
                thr_q <= thr_wdata;
            if (mask_wr)
                mask_q <= mask_wdata;
        end
    end

    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (set_v[b])
                bit_q <= 1'b1;
            else if (clr_wr && clr_data[b])
                bit_q <= 1'b0;
        end
        assign flags_q[b] = bit_q;

        // Flag holds unless a clear hits it (R7)
        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (bit_q && !(clr_wr && clr_data[b])) |=> bit_q);

        // External event sets its flag (R8)
        assert_evt_set_R8: assert property (@(posedge clk) disable iff (rst)
            evt_set[b] |=> bit_q);
    end

    assign thr   = thr_q;
    assign mask  = mask_q;
    assign flags = flags_q;
    assign irq   = |(flags_q & mask_q);

    // Dropped push raises the overrun flag (R3)
    assert_err_flag_R3: assert property (@(posedge clk) disable iff (rst)
        overrun |=> flags_q[FLG_IN_OVRUN]);

    // Reaching the threshold raises the fill flag (R6)
    assert_thr_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (fill >= thr_q) |=> flags_q[FLG_FILL_HIT]);

endmodule

// File: rtl/cbuf_sample_ring.sv
module cbuf_sample_ring
    import cbuf_pkg::*;
#(
    parameter int unsigned DEPTH  = 2003,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              host_rd_en,
    input  logic [PTR_W-1:0]  host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              rear_wr,
    input  logic [PTR_W-1:0]  rear_wdata,
    input  logic              thresh_wr,
    input  logic [PTR_W-1:0]  thresh_wdata,
    input  logic              mask_wr,
    input  logic [7:0]        mask_wdata,
    input  logic              flag_clr_wr,
    input  logic [7:0]        flag_clr_data,
    input  logic [7:0]        evt_set,
    output logic [PTR_W-1:0]  front_ptr,
    output logic [PTR_W-1:0]  rear_ptr,
    output logic [PTR_W-1:0]  fill_level,
    output logic [PTR_W-1:0]  threshold,
    output logic [7:0]        int_mask,
    output logic [7:0]        int_flags,
    output logic              irq
);

    logic [PTR_W-1:0] front_w, rear_w, fill_w;
    logic             full_w, push_ok_w;

    cbuf_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .push       (prod_valid),
        .rear_wr    (rear_wr),
        .rear_wdata (rear_wdata),
        .front      (front_w),
        .rear       (rear_w),
        .fill       (fill_w),
        .full       (full_w),
        .push_ok    (push_ok_w)
    );

    cbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push_ok_w),
        .wr_addr (front_w),
        .wr_data (prod_data),
        .rd_en   (host_rd_en),
        .rd_addr (host_rd_addr),
        .rd_data (host_rd_data)
    );

    cbuf_irq_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .fill       (fill_w),
        .overrun    (prod_valid && full_w),
        .thr_wr     (thresh_wr),
        .thr_wdata  (thresh_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .clr_wr     (flag_clr_wr),
        .clr_data   (flag_clr_data),
        .evt_set    (evt_set),
        .thr        (threshold),
        .mask       (int_mask),
        .flags      (int_flags),
        .irq        (irq)
    );

    assign front_ptr  = front_w;
    assign rear_ptr   = rear_w;
    assign fill_level = fill_w;

    // All-zero mask keeps the line quiet (R9)
    assert_mask_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (int_mask == 8'h00) |-> !irq);

endmodule

// File: tb/cbuf_sample_ring_tb.sv
`timescale 1ns/1ps
module cbuf_sample_ring_tb;

    localparam int DEPTH  = 2003;
    localparam int DATA_W = 16;
    localparam int PTR_W  = $clog2(DEPTH);

    logic clk = 0;
    logic rst = 1;
    logic prod_valid = 0;
    logic [DATA_W-1:0] prod_data = '0;
    logic host_rd_en = 0;
    logic [PTR_W-1:0] host_rd_addr = '0;
    logic [DATA_W-1:0] host_rd_data;
    logic rear_wr = 0;
    logic [PTR_W-1:0] rear_wdata = '0;
    logic thresh_wr = 0;
    logic [PTR_W-1:0] thresh_wdata = '0;
    logic mask_wr = 0;
    logic [7:0] mask_wdata = '0;
    logic flag_clr_wr = 0;
    logic [7:0] flag_clr_data = '0;
    logic [7:0] evt_set = '0;
    logic [PTR_W-1:0] front_ptr, rear_ptr, fill_level, threshold;
    logic [7:0] int_mask, int_flags;
    logic irq;

    always #10 clk = ~clk;

    cbuf_sample_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .prod_valid(prod_valid), .prod_data(prod_data),
        .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .rear_wr(rear_wr), .rear_wdata(rear_wdata),
        .thresh_wr(thresh_wr), .thresh_wdata(thresh_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data),
        .evt_set(evt_set),
        .front_ptr(front_ptr), .rear_ptr(rear_ptr), .fill_level(fill_level),
        .threshold(threshold), .int_mask(int_mask), .int_flags(int_flags), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_mem [DEPTH];
    int m_front, m_rear, m_flags, m_mask, m_thr, m_rd;
    bit m_live = 0;

    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_front = 0; m_rear = 0; m_flags = 0; m_mask = 0;
            m_thr = DEPTH / 2; m_rd = 0;
        end else begin
            int lvl, setv;
            lvl  = (m_front - m_rear + DEPTH) % DEPTH;
            setv = int'(evt_set);
            if (prod_valid && lvl == DEPTH - 1) setv |= 2;
            if (lvl >= m_thr) setv |= 1;
            if (host_rd_en) m_rd = (int'(host_rd_addr) < DEPTH) ? m_mem[host_rd_addr] : 0;
            if (prod_valid && lvl != DEPTH - 1) begin
                m_mem[m_front] = int'(prod_data);
                m_front = (m_front + 1) % DEPTH;
            end
            if (rear_wr && int'(rear_wdata) < DEPTH) m_rear = int'(rear_wdata);
            if (flag_clr_wr) m_flags &= ~int'(flag_clr_data);
            m_flags = (m_flags | setv) & 8'hFF;
            if (mask_wr) m_mask = int'(mask_wdata);
            if (thresh_wr) m_thr = int'(thresh_wdata);
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (m_live && !rst && !done) begin
            chk("R2", "front_ptr", front_ptr, m_front);
            chk("R5", "rear_ptr", rear_ptr, m_rear);
            chk("R4", "fill_level", fill_level, (m_front - m_rear + DEPTH) % DEPTH);
            chk("R7", "int_flags", int_flags, m_flags);
            chk("R9", "irq", irq, ((m_flags & m_mask) != 0) ? 1 : 0);
            chk("R9", "int_mask", int_mask, m_mask);
            chk("R6", "threshold", threshold, m_thr);
            chk("R10", "host_rd_data", host_rd_data, m_rd);
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        prod_valid = 0; host_rd_en = 0; rear_wr = 0; thresh_wr = 0;
        mask_wr = 0; flag_clr_wr = 0; evt_set = '0;
    endtask

    task automatic push_n(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            prod_valid = 1;
            prod_data  = 16'((i + seed) * 37 + 5);
            step();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        m_live = 1;
        // R1 reset state
        chk("R1", "front", front_ptr, 0);
        chk("R1", "rear", rear_ptr, 0);
        chk("R1", "fill", fill_level, 0);
        chk("R1", "flags", int_flags, 0);
        chk("R1", "mask", int_mask, 0);
        chk("R1", "threshold", threshold, 1001);
        chk("R1", "rd_data", host_rd_data, 0);

        // R8 event with mask zero: flag set, line low (R9)
        evt_set = 8'h80; step();
        chk("R8", "cmd done flag", int_flags[7], 1);
        chk("R9", "irq masked off", irq, 0);
        mask_wr = 1; mask_wdata = 8'hFF; step();
        chk("R9", "irq enabled", irq, 1);

        // R7 clear bit7; set and clear bit6 on same edge
        flag_clr_wr = 1; flag_clr_data = 8'h80; step();
        chk("R7", "bit7 cleared", int_flags[7], 0);
        evt_set = 8'h40; flag_clr_wr = 1; flag_clr_data = 8'h40; step();
        chk("R7", "set wins bit6", int_flags[6], 1);
        flag_clr_wr = 1; flag_clr_data = 8'hFF; step();

        // R2 push five and read back (R10)
        push_n(5, 0);
        for (int i = 0; i < 5; i++) begin
            host_rd_en = 1; host_rd_addr = PTR_W'(i); step();
        end
        chk("R10", "read idx4", host_rd_data, 16'((4) * 37 + 5));
        step();

        // R5 valid then out-of-range consumer write
        rear_wr = 1; rear_wdata = 11'd5; step();
        rear_wr = 1; rear_wdata = 11'd2047; step();
        chk("R5", "rear after bad write", rear_ptr, 5);
        chk("R4", "fill empty", fill_level, 0);

        // R6 threshold 4
        thresh_wr = 1; thresh_wdata = 11'd4; step();
        push_n(4, 100);
        chk("R6", "fill flag not yet", int_flags[0], 0);
        step();
        chk("R6", "fill flag set", int_flags[0], 1);

        // R3 fill to capacity and beyond, wrapping the write index (R2)
        push_n(2000, 7);
        chk("R3", "fill at capacity", fill_level, DEPTH - 1);
        chk("R3", "overrun flag", int_flags[1], 1);
        chk("R2", "front wrapped", front_ptr, 4);

        // R10 read last slot, out-of-range read
        host_rd_en = 1; host_rd_addr = 11'd2002; step();
        host_rd_en = 1; host_rd_addr = 11'd2047; step();
        chk("R10", "oob read", host_rd_data, 0);
        repeat (2) step();

        // Drain, then same-edge read and push at idx 4 (R10)
        rear_wr = 1; rear_wdata = 11'd4; step();
        chk("R4", "drained", fill_level, 0);
        host_rd_en = 1; host_rd_addr = 11'd4;
        prod_valid = 1; prod_data = 16'hBEEF; step();
        chk("R10", "read before write", host_rd_data, 16'((2002 - 1994) * 0 + 0) + m_rd);
        host_rd_en = 1; host_rd_addr = 11'd4; step();
        chk("R10", "new content", host_rd_data, 16'hBEEF);

        // R9 mask zero silences line
        mask_wr = 1; mask_wdata = 8'h00; step();
        chk("R9", "irq after mask zero", irq, 0);
        repeat (3) step();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule